// File: doc/BRIEF.md
# Card Read Data Receiver

This block sits on the host side of a memory-card bus and receives the data lines during single-block and multi-block reads. Command issue and response parsing are handled elsewhere. The block only gets two strobes: one for the cycle in which the read command's end bit goes out, and one for the stop command's end bit. The first strobe arms the receiver. The receiver then waits a bounded number of cycles for a start bit. After the start bit it shifts in a block of the configured byte length on 1, 4 or 8 lines and checks a separate 16-bit CRC on each active line. It then checks the closing end bit.

Received bytes leave on a valid/ready stream. Each block ends with a one-cycle completion pulse, and CRC and end-bit errors are flagged together with that pulse. In multi-block mode the receiver re-arms after every end bit and waits again for the next start bit. A stop command ends the stream. Data on the lines is still used up to the second cycle after the stop command's end bit. After that the receiver drops any block in progress and returns to idle.

Top module: `mmc_rd_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `blk_done`, `err_crc`, `err_end` and `err_timeout` are low.
- R2: A `rd_cmd_end` pulse in idle arms the receiver. While armed, the first cycle with `dat_in[0]` low is taken as the start bit, and data begins in the following cycle. While idle, activity on the lines is ignored.
- R3: The arming cycle is cycle A. If no start bit has come in cycles A+1 to A+T (T = `cfg_timeout`, at least 1), `err_timeout` pulses for one cycle, one cycle after cycle A+T, and the receiver goes idle. A start bit in cycle A+T is still accepted.
- R4: `cfg_width` 0 selects 1 line (`dat_in[0]`, MSB first), 1 selects 4 lines and 2 selects 8 lines. With 4 lines each cycle carries one nibble with `dat_in[3]` as its MSB, and the high nibble comes first. With 8 lines `dat_in[7]` is the MSB. Each completed byte is presented one cycle after its last bit.
- R5: A block is `cfg_blk_len` bytes, then 16 CRC cycles, then one end-bit cycle. `blk_done` pulses one cycle after the end-bit cycle.
- R6: Each active line carries its own CRC16 (polynomial 0x1021, zero seed, computed over that line's data bits) in the 16 cycles after the data, MSB first. Any mismatch raises `err_crc` together with `blk_done`.
- R7: If any active line is low in the end-bit cycle, `err_end` is raised together with `blk_done`. The block's bytes are still delivered.
- R8: With `cfg_multi` low the receiver goes idle after the end bit, and a later low on `dat_in[0]` produces nothing. With `cfg_multi` high it re-arms at the end bit. The end-bit cycle then plays the role of A in R3.
- R9: Call the cycle in which `stop_cmd_end` is high cycle S. Line data up to and including cycle S+2 is still used. After that any partial block is dropped and gives no `blk_done`. A stop during the wait for a start bit returns the receiver to idle with no `err_timeout`.
- R10: `out_valid` stays high until `out_ready` is high. A newly completed byte replaces a byte that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Line count select: 0 = 1, 1 = 4, 2 = 8 |
| cfg_multi | input | 1 | Re-arm after each block (multi-block read) |
| cfg_blk_len | input | LEN_W | Block length in bytes |
| cfg_timeout | input | TO_W | Start-bit wait limit in cycles |
| rd_cmd_end | input | 1 | Read command end-bit strobe |
| stop_cmd_end | input | 1 | Stop command end-bit strobe |
| dat_in | input | 8 | Card data lines |
| out_ready | input | 1 | Byte sink ready |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Received byte |
| blk_done | output | 1 | Block finished pulse |
| err_crc | output | 1 | CRC mismatch on some active line |
| err_end | output | 1 | End bit sampled low |
| err_timeout | output | 1 | No start bit within the wait limit |

## Verification
Two events can land in the same cycle: the last data bit of a block and the stop command's end bit. The stream cut-off then competes with byte delivery. The bench asserts the stop strobe partway through a block's data, so the stop window closes on a byte boundary. It then expects exactly the bytes whose last bit falls on or before the second cycle after the stop, and no completion pulse for that block. A second collision is a completed byte arriving while the sink is stalled. The bench expects the new byte to replace the pending one, with valid held high throughout.

// File: rtl/mmc_rx_pkg.sv
package mmc_rx_pkg;

    localparam int NUM_LANES = 8;
    localparam int CRC_BITS  = 16;
    localparam logic [CRC_BITS-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_CRC,
        ST_END
    } rx_state_e;

    typedef enum logic [1:0] {
        BW_1 = 2'd0,
        BW_4 = 2'd1,
        BW_8 = 2'd2
    } bus_width_e;

    function automatic logic [NUM_LANES-1:0] lane_mask(input logic [1:0] w);
        case (w)
            BW_1:    return 8'h01;
            BW_4:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [1:0] width_log2(input logic [1:0] w);
        case (w)
            BW_1:    return 2'd0;
            BW_4:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [2:0] cycles_per_byte_m1(input logic [1:0] w);
        case (w)
            BW_1:    return 3'd7;
            BW_4:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [CRC_BITS-1:0] crc16_step(input logic [CRC_BITS-1:0] c,
                                                       input logic b);
        logic fb;
        fb = b ^ c[CRC_BITS-1];
        return {c[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/mmc_rx_crc_lane.sv
module mmc_rx_crc_lane
    import mmc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic shf,
    input  logic bit_in,
    output logic crc_msb
);

    logic [CRC_BITS-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc16_step(crc_q, bit_in);
        end else if (shf) begin
            crc_q <= {crc_q[CRC_BITS-2:0], 1'b0};
        end
    end

    assign crc_msb = crc_q[CRC_BITS-1];

    // R6: every block starts its line checksum from a zero seed
    p_seed_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_q == '0));

endmodule

// File: rtl/mmc_rx_packer.sv
module mmc_rx_packer
    import mmc_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic [1:0]           width,
    input  logic [NUM_LANES-1:0] dat,
    output logic                 byte_ok,
    output logic [7:0]           byte_out
);

    logic [7:0] acc_q;
    logic [7:0] acc_nxt;
    logic [2:0] ph_q;
    logic [2:0] ph_last;

    assign ph_last = cycles_per_byte_m1(width);

    always_comb begin
        case (width)
            BW_1:    acc_nxt = {acc_q[6:0], dat[0]};
            BW_4:    acc_nxt = {acc_q[3:0], dat[3:0]};
            default: acc_nxt = dat[7:0];
        endcase
    end

    assign byte_ok  = en && (ph_q == ph_last);
    assign byte_out = acc_nxt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            ph_q  <= '0;
        end else if (en) begin
            acc_q <= acc_nxt;
            ph_q  <= byte_ok ? 3'd0 : ph_q + 3'd1;
        end
    end

    // R4: the bit phase never passes the byte boundary of the chosen width
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ph_q <= cycles_per_byte_m1(width));

endmodule

// File: rtl/mmc_rd_rx.sv
module mmc_rd_rx
    import mmc_rx_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_multi,
    input  logic [LEN_W-1:0] cfg_blk_len,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             rd_cmd_end,
    input  logic             stop_cmd_end,
    input  logic [7:0]       dat_in,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             blk_done,
    output logic             err_crc,
    output logic             err_end,
    output logic             err_timeout
);

    localparam int CNT_W = LEN_W + 3;
    localparam int CRC_CW = $clog2(CRC_BITS);

    rx_state_e              state_q;
    logic [TO_W-1:0]        wcnt_q;
    logic [CNT_W-1:0]       dcnt_q;
    logic [CRC_CW-1:0]      ccnt_q;
    logic                   crc_bad_q;
    logic                   stop_d1_q, stop_d2_q;

    logic [NUM_LANES-1:0]   mask;
    logic [CNT_W-1:0]       data_cycles;
    logic                   start_hit;
    logic                   stop_any;
    logic [NUM_LANES-1:0]   lane_msb;
    logic                   crc_mis;
    logic                   byte_ok;
    logic [7:0]             byte_val;

    assign mask        = lane_mask(cfg_width);
    assign data_cycles = {cfg_blk_len, 3'b000} >> width_log2(cfg_width);
    assign start_hit   = (state_q == ST_WAIT) && !dat_in[0] && !stop_any;
    assign stop_any    = stop_cmd_end || stop_d1_q || stop_d2_q;
    assign crc_mis     = |((dat_in ^ lane_msb) & mask);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        mmc_rx_crc_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (start_hit),
            .upd     ((state_q == ST_DATA) && mask[i]),
            .shf     (state_q == ST_CRC),
            .bit_in  (dat_in[i]),
            .crc_msb (lane_msb[i])
        );
    end

    mmc_rx_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_hit),
        .en       (state_q == ST_DATA),
        .width    (cfg_width),
        .dat      (dat_in),
        .byte_ok  (byte_ok),
        .byte_out (byte_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            wcnt_q      <= '0;
            dcnt_q      <= '0;
            ccnt_q      <= '0;
            crc_bad_q   <= 1'b0;
            stop_d1_q   <= 1'b0;
            stop_d2_q   <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            blk_done    <= 1'b0;
            err_crc     <= 1'b0;
            err_end     <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            stop_d1_q   <= stop_cmd_end;
            stop_d2_q   <= stop_d1_q;
            blk_done    <= 1'b0;
            err_crc     <= 1'b0;
            err_end     <= 1'b0;
            err_timeout <= 1'b0;

            if (byte_ok) begin
                out_valid <= 1'b1;
                out_data  <= byte_val;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end

            case (state_q)
                ST_IDLE: begin
                    if (rd_cmd_end) begin
                        state_q <= ST_WAIT;
                        wcnt_q  <= '0;
                    end
                end
                ST_WAIT: begin
                    if (stop_any) begin
                        state_q <= ST_IDLE;
                    end else if (!dat_in[0]) begin
                        state_q   <= ST_DATA;
                        dcnt_q    <= '0;
                        crc_bad_q <= 1'b0;
                    end else if (wcnt_q == cfg_timeout - TO_W'(1)) begin
                        err_timeout <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        wcnt_q <= wcnt_q + TO_W'(1);
                    end
                end
                ST_DATA: begin
                    if (dcnt_q == data_cycles - CNT_W'(1)) begin
                        state_q <= ST_CRC;
                        ccnt_q  <= '0;
                    end else begin
                        dcnt_q <= dcnt_q + CNT_W'(1);
                    end
                end
                ST_CRC: begin
                    crc_bad_q <= crc_bad_q | crc_mis;
                    if (ccnt_q == CRC_CW'(CRC_BITS - 1)) begin
                        state_q <= ST_END;
                    end else begin
                        ccnt_q <= ccnt_q + CRC_CW'(1);
                    end
                end
                ST_END: begin
                    blk_done <= 1'b1;
                    err_crc  <= crc_bad_q;
                    err_end  <= |(~dat_in & mask);
                    state_q  <= cfg_multi ? ST_WAIT : ST_IDLE;
                    wcnt_q   <= '0;
                end
                default: state_q <= ST_IDLE;
            endcase

            if (stop_d2_q) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // R2: a read end strobe in idle leads to the armed state
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rd_cmd_end && !stop_d2_q) |=> (state_q == ST_WAIT));

    // R3: the wait counter stays inside the programmed window
    p_wait_window_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && cfg_timeout != '0) |-> (wcnt_q < cfg_timeout));

    // R6: a CRC error flag only appears on a completed block
    p_crc_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        err_crc |-> blk_done);

    // R7: an end-bit error flag only appears on a completed block
    p_end_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        err_end |-> blk_done);

    // R9: the stop window closing always leaves the receiver idle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        stop_d2_q |=> (state_q == ST_IDLE));

    // R10: an untaken byte stays offered
    p_hold_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

endmodule

// File: tb/test_mmc_rd_rx.sv
module test_mmc_rd_rx;

    localparam int T = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_multi = 1'b0;
    logic [11:0] cfg_blk_len = 12'd1;
    logic [15:0] cfg_timeout = 16'(T);
    logic        rd = 1'b0, stp = 1'b0, rdy = 1'b1;
    logic [7:0]  dat = 8'hFF;
    logic        out_valid, blk_done, err_crc, err_end, err_timeout;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    mmc_rd_rx i_mmc_rd_rx (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_multi(cfg_multi),
        .cfg_blk_len(cfg_blk_len), .cfg_timeout(cfg_timeout),
        .rd_cmd_end(rd), .stop_cmd_end(stp), .dat_in(dat), .out_ready(rdy),
        .out_valid(out_valid), .out_data(out_data), .blk_done(blk_done),
        .err_crc(err_crc), .err_end(err_end), .err_timeout(err_timeout)
    );

    int cyc = 0;
    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic       mvalid = 1'b0;
    logic [7:0] mdata = 8'h00;
    logic [7:0] eb[int];
    bit ed[int], ec[int], ee[int], et[int];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s slot=%0d act=%0h exp=%0h", req, cyc, act, exp);
        end
    endtask

    // behavioural model of the outputs, compared on every clock
    task automatic compare_now();
        bit xd, xc, xe, xt;
        if (rst) mvalid = 1'b0;
        else if (eb.exists(cyc)) begin mvalid = 1'b1; mdata = eb[cyc]; end
        else if (rdy) mvalid = 1'b0;
        xd = !rst && ed.exists(cyc);
        xc = !rst && ec.exists(cyc);
        xe = !rst && ee.exists(cyc);
        xt = !rst && et.exists(cyc);
        chk(out_valid == mvalid, "R10 out_valid", 32'(out_valid), 32'(mvalid));
        if (mvalid) chk(out_data == mdata, "R4 out_data", 32'(out_data), 32'(mdata));
        chk(blk_done == xd, "R5 blk_done", 32'(blk_done), 32'(xd));
        chk(err_crc == xc, "R6 err_crc", 32'(err_crc), 32'(xc));
        chk(err_end == xe, "R7 err_end", 32'(err_end), 32'(xe));
        chk(err_timeout == xt, "R3 err_timeout", 32'(err_timeout), 32'(xt));
    endtask

    int last_slot = 0;
    task automatic step(input logic [7:0] d, input logic r, input logic s);
        @(negedge clk);
        compare_now();
        dat = d; rd = r; stp = s;
        last_slot = cyc + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'hFF, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] w);
        return (w == 2'd0) ? 8'h01 : (w == 2'd1) ? 8'h0F : 8'hFF;
    endfunction

    // gap idle cycles, start bit, data, per-line CRC, end bit
    task automatic send_blk(input logic [7:0] data[$], input int gap, input int bad_lane,
                            input bit bad_end, input int stop_at);
        logic [7:0]  m;
        logic [15:0] crc[8];
        logic [7:0]  v;
        int n, cpb, t0, s, k;
        m = mask_of(cfg_width);
        cpb = (cfg_width == 2'd0) ? 8 : (cfg_width == 2'd1) ? 2 : 1;
        n = data.size() * cpb;
        for (int i = 0; i < 8; i++) crc[i] = 16'h0;
        idle(gap);
        step(~m, 1'b0, 1'b0);
        t0 = last_slot;
        s = (stop_at >= 0) ? t0 + 1 + stop_at : -100;
        for (int j = 0; j < data.size(); j++)
            if (stop_at < 0 || t0 + (j + 1) * cpb <= s + 2) eb[t0 + (j + 1) * cpb] = data[j];
        if (stop_at < 0) begin
            ed[t0 + n + 17] = 1'b1;
            if (bad_lane >= 0) ec[t0 + n + 17] = 1'b1;
            if (bad_end) ee[t0 + n + 17] = 1'b1;
        end
        for (k = 0; k < n; k++) begin
            if (cfg_width == 2'd2) v = data[k];
            else if (cfg_width == 2'd1) v = {4'hF, (k % 2 == 0) ? data[k/2][7:4] : data[k/2][3:0]};
            else v = {7'h7F, data[k/8][7 - (k % 8)]};
            for (int i = 0; i < 8; i++)
                if (m[i]) crc[i] = {crc[i][14:0], 1'b0} ^ ((v[i] ^ crc[i][15]) ? 16'h1021 : 16'h0);
            step(v, 1'b0, (stop_at == k));
        end
        for (int j = 0; j < 16; j++) begin
            v = 8'hFF;
            for (int i = 0; i < 8; i++) if (m[i]) v[i] = crc[i][15 - j];
            if (bad_lane >= 0 && j == 5) v[bad_lane] = ~v[bad_lane];
            step(v, 1'b0, 1'b0);
        end
        step(bad_end ? 8'hFE : 8'hFF, 1'b0, 1'b0);
    endtask

    task automatic arm();
        step(8'hFF, 1'b1, 1'b0);
    endtask

    initial begin
        int a;
        logic [7:0] q[$];
        // R1: reset state
        for (int i = 0; i < 4; i++) step(8'hFF, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !blk_done && !err_crc && !err_end && !err_timeout, "R1 reset",
            {27'd0, out_valid, blk_done, err_crc, err_end, err_timeout}, 32'd0);
        // R2: lows on line 0 while idle are ignored
        for (int i = 0; i < 5; i++) step(8'h00, 1'b0, 1'b0);
        idle(3);
        // R2 R4 R5: one line, three bytes
        cfg_width = 2'd0; cfg_blk_len = 12'd3;
        arm(); q = '{8'hA5, 8'h3C, 8'h81}; send_blk(q, 4, -1, 1'b0, -1); idle(3);
        // R4: four lines, start right after arming
        cfg_width = 2'd1; cfg_blk_len = 12'd4;
        arm(); q = '{8'h12, 8'hF0, 8'h9E, 8'h47}; send_blk(q, 0, -1, 1'b0, -1); idle(3);
        // R3 boundary: start in the last allowed cycle, eight lines
        cfg_width = 2'd2; cfg_blk_len = 12'd8;
        arm(); q = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A, 8'hC3, 8'h7E, 8'h24};
        send_blk(q, T - 1, -1, 1'b0, -1); idle(3);
        // R6: CRC corrupted on line 3
        cfg_width = 2'd1; cfg_blk_len = 12'd2;
        arm(); q = '{8'hDE, 8'hAD}; send_blk(q, 2, 3, 1'b0, -1); idle(3);
        // R7: end bit low, bytes still delivered
        cfg_width = 2'd0; cfg_blk_len = 12'd1;
        arm(); q = '{8'h6B}; send_blk(q, 1, -1, 1'b1, -1);
        // R8: single mode, later start bits produce nothing
        for (int i = 0; i < 20; i++) step(8'hFE, 1'b0, 1'b0);
        idle(3);
        // R3: no start bit at all
        arm(); a = last_slot; et[a + T] = 1'b1; idle(T + 4);
        // R8 R9: two blocks in multi mode, stop while waiting
        cfg_multi = 1'b1; cfg_width = 2'd2; cfg_blk_len = 12'd4;
        arm(); q = '{8'h11, 8'h22, 8'h33, 8'h44}; send_blk(q, 3, -1, 1'b0, -1);
        q = '{8'hAA, 8'hBB, 8'hCC, 8'hDD}; send_blk(q, T - 1, -1, 1'b0, -1);
        idle(2); step(8'hFF, 1'b0, 1'b1); idle(T + 6);
        // R9: stop in the middle of the second block
        cfg_width = 2'd1; cfg_blk_len = 12'd8;
        arm(); q = '{8'h10, 8'h32, 8'h54, 8'h76, 8'h98, 8'hBA, 8'hDC, 8'hFE};
        send_blk(q, 1, -1, 1'b0, -1);
        q = '{8'h0F, 8'h1E, 8'h2D, 8'h3C, 8'h4B, 8'h5A, 8'h69, 8'h78};
        send_blk(q, 2, -1, 1'b0, 5);
        idle(T + 4);
        cfg_multi = 1'b0;
        // R10: sink stalled, second byte replaces the first
        cfg_width = 2'd0; cfg_blk_len = 12'd2;
        rdy = 1'b0;
        arm(); q = '{8'hC7, 8'h39}; send_blk(q, 2, -1, 1'b0, -1);
        idle(3); rdy = 1'b1; idle(4);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog R5 act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule